// File: doc/BRIEF.md
# DMA Controller Register Front End

This block is the register-side front end of a multi-channel DMA controller. A simple 32-bit register bus reaches two regions. The global region holds the interrupt status, mask and clear words, the controller configuration word and a sync word. The channel region holds a bank of five words for each channel: source address, destination address, next-descriptor pointer, control and configuration. The channel count is the parameter `NUM_CH`, and it is either 8 or 2.

The transfer engine reports completions and faults through per-channel pulses on `tc_set` and `err_set`. The block keeps these as sticky status bits. It qualifies them with the masks and drives a terminal-count interrupt line, an error interrupt line and a combined line. When software writes a channel configuration word while the controller is enabled, the block issues a one-cycle start request that names the channel. The data movement itself is done elsewhere.

The register bus is accepted on every cycle that `bus_valid` is high. There is no back-pressure: `bus_valid` is a qualifier, not a handshake. Every read gets exactly one response beat, and the consumer must take that beat in the cycle it appears. The start request is a plain pulse, and the engine must capture it in that cycle.

Top module: `dmaf_regs_top`

## Requirements
- R1: The channel region is `bus_addr[11:8]==1`. Within it, `bus_addr[7:5]` picks the channel and `bus_addr[4:2]` picks the word: 0 source, 1 destination, 2 next pointer, 3 control, 4 configuration. A read returns the value last written to that word of that channel.
- R2: Every accepted read (`bus_valid` high, `bus_write` low) gives `rd_valid` high for one cycle. It comes in the cycle after acceptance, with the data on `rd_data`. `rd_valid` is never high without such a read.
- R3: A bad address raises `bad_addr` for one cycle, in the cycle after acceptance. A bad address is one of three cases: a channel index at or above `NUM_CH`, a channel word of 5 to 7, or an address in neither region. A bad read returns zero, and a bad write changes no register.
- R4: A write to a channel word changes no global register, even when its low bits match a global word offset.
- R5: The global region is `bus_addr[11:5]==0`, and `bus_addr[4:2]` picks the word. Word 0 is the terminal-count status (read only). Word 1 is the terminal-count mask. Word 2 clears terminal-count status (write 1 to clear). Word 3 is the error status (read only). Word 4 is the error mask. Word 5 clears error status (write 1 to clear). Word 6 is the configuration word. Word 7 is the sync word.
- R6: A high bit on `tc_set` or `err_set` sets the matching status bit. The bit stays set until it is cleared. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R7: `irq_tc` is high when any bit of (terminal-count status AND its mask) is set. `irq_err` is high when any bit of (error status AND its mask) is set. `irq_any` is their OR. All three follow register state, so they change in the cycle after the write or set that caused the change.
- R8: Configuration bit 0 enables the controller. Bits 1 and 2 select the byte order of the two bus masters. The three bits appear on `glob_cfg`. A write to a channel configuration word while bit 0 is set gives `start_valid` for one cycle, in the cycle after the write, with the channel on `start_chan`. No start is issued while the controller is disabled.
- R9: Status, mask and sync words are `NUM_CH` bits wide. Their bits at and above `NUM_CH` read as zero.
- R10: Reset clears every status, mask, configuration and sync register and every channel word to zero. All outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| tc_set | input | NUM_CH | Per-channel terminal-count event pulses |
| err_set | input | NUM_CH | Per-channel error event pulses |
| rd_valid | output | 1 | Read response beat |
| rd_data | output | 32 | Read response data |
| bad_addr | output | 1 | Previous access was to a bad address |
| start_valid | output | 1 | Start request to the transfer engine |
| start_chan | output | 3 | Channel of the start request |
| glob_cfg | output | 3 | Enable and master byte-order bits |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_err | output | 1 | Masked error interrupt |
| irq_any | output | 1 | OR of the two interrupt lines |

## Verification
Read data, `bad_addr` and `start_valid` all appear in the single cycle after the clock edge that accepts the access. Interrupt levels and register contents change on that same edge, so their effects are visible in the following cycle. The bench drives each access on a falling edge and samples on the next falling edge, after exactly one rising edge has passed. Each expected read response is pushed into a queue when the read is issued. A monitor pops an entry from that queue at every falling edge where `rd_valid` is high, so a response that comes late, comes twice or never comes shows up as a mismatch or a leftover entry.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int MAX_CH = 8;

  // per-channel word selectors (bus_addr[4:2])
  localparam logic [2:0] CW_SRC  = 3'd0;
  localparam logic [2:0] CW_DST  = 3'd1;
  localparam logic [2:0] CW_NEXT = 3'd2;
  localparam logic [2:0] CW_CTRL = 3'd3;
  localparam logic [2:0] CW_CFG  = 3'd4;

  // global word selectors (bus_addr[4:2])
  localparam logic [2:0] GW_TC_STAT = 3'd0;
  localparam logic [2:0] GW_TC_MASK = 3'd1;
  localparam logic [2:0] GW_TC_CLR  = 3'd2;
  localparam logic [2:0] GW_ER_STAT = 3'd3;
  localparam logic [2:0] GW_ER_MASK = 3'd4;
  localparam logic [2:0] GW_ER_CLR  = 3'd5;
  localparam logic [2:0] GW_CFG     = 3'd6;
  localparam logic [2:0] GW_SYNC    = 3'd7;

  typedef struct packed {
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] dst;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] cfg;
  } chan_bank_t;

  typedef struct packed {
    logic       chan_hit;
    logic       glob_hit;
    logic [2:0] idx;
    logic [2:0] word;
  } dec_t;
endpackage

// File: rtl/dmaf_decode.sv
module dmaf_decode
  import dmaf_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic              bad
);
  logic in_chan_region;
  logic unused_low;

  assign unused_low     = ^addr[1:0];
  assign in_chan_region = (addr[11:8] == 4'h1);

  always_comb begin
    dec.idx      = addr[7:5];
    dec.word     = addr[4:2];
    dec.chan_hit = in_chan_region && (int'(addr[7:5]) < NUM_CH) && (addr[4:2] <= CW_CFG);
    dec.glob_hit = (addr[11:5] == 7'd0);
    bad          = !(dec.chan_hit || dec.glob_hit);
  end
endmodule

// File: rtl/dmaf_chan_regs.sv
module dmaf_chan_regs
  import dmaf_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        idx,
  input  logic [2:0]        word,
  input  logic [DATA_W-1:0] wdata,
  input  logic              enable,
  output logic [DATA_W-1:0] rdata,
  output logic              start_valid,
  output logic [2:0]        start_chan
);
  chan_bank_t bank_all [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_bank_t bank_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q <= '0;
      end else if (wr_en && idx == 3'(c)) begin
        case (word)
          CW_SRC:  bank_q.src  <= wdata;
          CW_DST:  bank_q.dst  <= wdata;
          CW_NEXT: bank_q.nxt  <= wdata;
          CW_CTRL: bank_q.ctrl <= wdata;
          CW_CFG:  bank_q.cfg  <= wdata;
          default: ;
        endcase
      end
    end
    assign bank_all[c] = bank_q;
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx == 3'(c)) begin
        case (word)
          CW_SRC:  rdata = bank_all[c].src;
          CW_DST:  rdata = bank_all[c].dst;
          CW_NEXT: rdata = bank_all[c].nxt;
          CW_CTRL: rdata = bank_all[c].ctrl;
          CW_CFG:  rdata = bank_all[c].cfg;
          default: rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_valid <= 1'b0;
      start_chan  <= '0;
    end else begin
      start_valid <= wr_en && (word == CW_CFG) && enable;
      start_chan  <= idx;
    end
  end
endmodule

// File: rtl/dmaf_irq.sv
module dmaf_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  input  logic              wr_tc_mask,
  input  logic              wr_tc_clr,
  input  logic              wr_err_mask,
  input  logic              wr_err_clr,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] tc_stat,
  output logic [NUM_CH-1:0] tc_mask,
  output logic [NUM_CH-1:0] err_stat,
  output logic [NUM_CH-1:0] err_mask,
  output logic              irq_tc,
  output logic              irq_err
);
  logic [NUM_CH-1:0] tc_clr_bits, err_clr_bits;

  assign tc_clr_bits  = wr_tc_clr  ? wbits : '0;
  assign err_clr_bits = wr_err_clr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_stat  <= '0;
      tc_mask  <= '0;
      err_stat <= '0;
      err_mask <= '0;
    end else begin
      tc_stat  <= (tc_stat  & ~tc_clr_bits)  | tc_set;
      err_stat <= (err_stat & ~err_clr_bits) | err_set;
      if (wr_tc_mask)  tc_mask  <= wbits;
      if (wr_err_mask) err_mask <= wbits;
    end
  end

  assign irq_tc  = |(tc_stat & tc_mask);
  assign irq_err = |(err_stat & err_mask);
endmodule

// File: rtl/dmaf_regs_top.sv
module dmaf_regs_top
  import dmaf_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bad_addr,
  output logic              start_valid,
  output logic [2:0]        start_chan,
  output logic [2:0]        glob_cfg,
  output logic              irq_tc,
  output logic              irq_err,
  output logic              irq_any
);
  localparam int PAD_W = DATA_W - NUM_CH;

  dec_t              dec;
  logic              dec_bad;
  logic              wr_acc, wr_glob, wr_chan;
  logic [DATA_W-1:0] chan_rdata, rd_next;
  logic [NUM_CH-1:0] tc_stat, tc_mask, err_stat, err_mask, sync_q;
  logic [2:0]        cfg_q;

  dmaf_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr (bus_addr),
    .dec  (dec),
    .bad  (dec_bad)
  );

  assign wr_acc  = bus_valid && bus_write;
  assign wr_chan = wr_acc && dec.chan_hit;
  assign wr_glob = wr_acc && dec.glob_hit;

  dmaf_chan_regs #(.NUM_CH(NUM_CH)) u_chan (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_chan),
    .idx         (dec.idx),
    .word        (dec.word),
    .wdata       (bus_wdata),
    .enable      (cfg_q[0]),
    .rdata       (chan_rdata),
    .start_valid (start_valid),
    .start_chan  (start_chan)
  );

  dmaf_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tc_set      (tc_set),
    .err_set     (err_set),
    .wr_tc_mask  (wr_glob && dec.word == GW_TC_MASK),
    .wr_tc_clr   (wr_glob && dec.word == GW_TC_CLR),
    .wr_err_mask (wr_glob && dec.word == GW_ER_MASK),
    .wr_err_clr  (wr_glob && dec.word == GW_ER_CLR),
    .wbits       (bus_wdata[NUM_CH-1:0]),
    .tc_stat     (tc_stat),
    .tc_mask     (tc_mask),
    .err_stat    (err_stat),
    .err_mask    (err_mask),
    .irq_tc      (irq_tc),
    .irq_err     (irq_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sync_q <= '0;
    end else if (wr_glob) begin
      if (dec.word == GW_CFG)  cfg_q  <= bus_wdata[2:0];
      if (dec.word == GW_SYNC) sync_q <= bus_wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (dec.chan_hit) begin
      rd_next = chan_rdata;
    end else if (dec.glob_hit) begin
      case (dec.word)
        GW_TC_STAT: rd_next = {{PAD_W{1'b0}}, tc_stat};
        GW_TC_MASK: rd_next = {{PAD_W{1'b0}}, tc_mask};
        GW_ER_STAT: rd_next = {{PAD_W{1'b0}}, err_stat};
        GW_ER_MASK: rd_next = {{PAD_W{1'b0}}, err_mask};
        GW_CFG:     rd_next = {{(DATA_W-3){1'b0}}, cfg_q};
        GW_SYNC:    rd_next = {{PAD_W{1'b0}}, sync_q};
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      bad_addr <= 1'b0;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      rd_data  <= (bus_valid && !bus_write) ? rd_next : '0;
      bad_addr <= bus_valid && dec_bad;
    end
  end

  assign glob_cfg = cfg_q;
  assign irq_any  = irq_tc || irq_err;
endmodule

// File: rtl/dmaf_regs_chk.sv
module dmaf_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        bad_addr,
  input logic        start_valid,
  input logic        irq_tc,
  input logic        irq_err,
  input logic        irq_any
);
  a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  a_r2_no_stray_response: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && !bus_write));

  a_r3_bad_read_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bad_addr) |-> (rd_data == 32'd0));

  a_r3_bad_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> $past(bus_valid));

  a_r8_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> $past(bus_valid && bus_write));

  a_r7_any_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (irq_tc || irq_err));
endmodule

bind dmaf_regs_top dmaf_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .bad_addr    (bad_addr),
  .start_valid (start_valid),
  .irq_tc      (irq_tc),
  .irq_err     (irq_err),
  .irq_any     (irq_any)
);

// File: tb/dmaf_regs_top_tb_top.sv
`timescale 1ns/1ps
module dmaf_regs_top_tb_top;
  localparam int NCH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [NCH-1:0] tc_set = '0, err_set = '0;
  logic          rd_valid, bad_addr, start_valid, irq_tc, irq_err, irq_any;
  logic [31:0]   rd_data;
  logic [2:0]    start_chan, glob_cfg;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] data; logic bad; string tag; } exp_t;
  exp_t rq[$];

  always #2 clk = ~clk;

  dmaf_regs_top #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tc_set(tc_set), .err_set(err_set),
    .rd_valid(rd_valid), .rd_data(rd_data), .bad_addr(bad_addr),
    .start_valid(start_valid), .start_chan(start_chan), .glob_cfg(glob_cfg),
    .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ca(input int ch, input int w);
    return 12'h100 | 12'(ch << 5) | 12'(w << 2);
  endfunction

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input logic b, input string tag);
    exp_t x;
    x.data = e; x.bad = b; x.tag = tag;
    rq.push_back(x);
    acc(1'b0, a, 32'd0);
  endtask

  task automatic pulse_tc(input logic [NCH-1:0] v);
    @(negedge clk); tc_set = v; @(negedge clk); tc_set = '0;
  endtask

  task automatic pulse_err(input logic [NCH-1:0] v);
    @(negedge clk); err_set = v; @(negedge clk); err_set = '0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R2 unexpected response", rd_data, 32'd0);
        end else begin
          exp_t x;
          x = rq.pop_front();
          chk(rd_data == x.data, x.tag, rd_data, x.data);
          chk(bad_addr == x.bad, {x.tag, " bad flag"}, 32'(bad_addr), 32'(x.bad));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk({rd_valid, bad_addr, start_valid, irq_tc, irq_err, irq_any} == 6'd0, "R10 outputs low", 32'(irq_any), 0);
    chk(glob_cfg == 3'd0, "R10 cfg cleared", 32'(glob_cfg), 0);
    rd(ca(0, 4), 0, 0, "R10 ch0 cfg zero");
    rd(ca(1, 0), 0, 0, "R10 ch1 src zero");
    rd(12'h004, 0, 0, "R10 tc mask zero");

    // R1 channel words round trip
    acc(1, ca(0, 0), 32'hA0A0_0001);
    acc(1, ca(0, 1), 32'hB0B0_0002);
    acc(1, ca(1, 2), 32'hC0C0_0003);
    acc(1, ca(1, 3), 32'hD0D0_0004);
    acc(1, ca(1, 4), 32'h0000_00E5);
    chk(start_valid == 1'b0, "R8 no start while disabled", 32'(start_valid), 0);
    rd(ca(0, 0), 32'hA0A0_0001, 0, "R1 ch0 src");
    rd(ca(0, 1), 32'hB0B0_0002, 0, "R1 ch0 dst");
    rd(ca(1, 2), 32'hC0C0_0003, 0, "R1 ch1 next");
    rd(ca(1, 3), 32'hD0D0_0004, 0, "R1 ch1 ctrl");
    rd(ca(1, 4), 32'h0000_00E5, 0, "R1 ch1 cfg");
    rd(ca(0, 2), 0, 0, "R1 ch0 next untouched");

    // R3 bad channel index, bad word, outside both regions
    rd(ca(2, 0), 0, 1, "R3 channel index 2 read");
    rd(ca(7, 1), 0, 1, "R3 channel index 7 read");
    rd(ca(0, 5), 0, 1, "R3 channel word 5 read");
    rd(12'h200, 0, 1, "R3 outside regions read");
    acc(1, ca(2, 0), 32'hFFFF_FFFF);
    chk(bad_addr == 1'b1, "R3 bad write flagged", 32'(bad_addr), 1);
    rd(ca(0, 0), 32'hA0A0_0001, 0, "R3 bad write left ch0 alone");

    // R6 set, R5 W1C clear, R4 channel write does not clear
    pulse_tc(2'b11);
    rd(12'h000, 32'h3, 0, "R6 tc status set");
    acc(1, ca(0, 2), 32'hFFFF_FFFF);
    rd(12'h000, 32'h3, 0, "R4 channel write left tc status");
    acc(1, 12'h008, 32'h1);
    rd(12'h000, 32'h2, 0, "R5 tc clear bit0 only");
    // R6 set wins over clear in the same cycle
    @(negedge clk);
    tc_set = 2'b01; bus_valid = 1; bus_write = 1; bus_addr = 12'h008; bus_wdata = 32'h1;
    @(negedge clk);
    tc_set = '0; bus_valid = 0; bus_write = 0;
    rd(12'h000, 32'h3, 0, "R6 set beats clear");

    // R7 interrupt levels
    chk(irq_tc == 1'b0 && irq_any == 1'b0, "R7 tc masked off", 32'(irq_tc), 0);
    acc(1, 12'h004, 32'hFF);
    chk(irq_tc == 1'b1 && irq_any == 1'b1 && irq_err == 1'b0, "R7 tc unmasked", 32'({irq_tc, irq_err, irq_any}), 32'b101);
    rd(12'h004, 32'h3, 0, "R9 tc mask upper bits zero");
    acc(1, 12'h008, 32'h3);
    chk(irq_tc == 1'b0 && irq_any == 1'b0, "R7 tc cleared", 32'(irq_tc), 0);
    pulse_err(2'b10);
    chk(irq_err == 1'b0, "R7 err masked off", 32'(irq_err), 0);
    acc(1, 12'h010, 32'h2);
    chk(irq_err == 1'b1 && irq_any == 1'b1 && irq_tc == 1'b0, "R7 err unmasked", 32'({irq_tc, irq_err, irq_any}), 32'b011);
    rd(12'h00C, 32'h2, 0, "R6 err status");
    acc(1, 12'h014, 32'h2);
    chk(irq_err == 1'b0 && irq_any == 1'b0, "R5 err cleared", 32'(irq_err), 0);

    // R9 sync width, R8 configuration and start
    acc(1, 12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, 32'h3, 0, "R9 sync upper bits zero");
    acc(1, 12'h018, 32'h7);
    chk(glob_cfg == 3'b111, "R8 cfg port", 32'(glob_cfg), 7);
    rd(12'h018, 32'h7, 0, "R8 cfg readback");
    acc(1, ca(1, 4), 32'h1);
    chk(start_valid == 1'b1 && start_chan == 3'd1, "R8 start ch1", 32'({start_valid, start_chan}), 32'b1001);
    @(negedge clk);
    chk(start_valid == 1'b0, "R8 start one cycle", 32'(start_valid), 0);
    acc(1, ca(0, 3), 32'h1);
    chk(start_valid == 1'b0, "R8 ctrl write no start", 32'(start_valid), 0);
    acc(1, ca(0, 4), 32'h1);
    chk(start_valid == 1'b1 && start_chan == 3'd0, "R8 start ch0", 32'({start_valid, start_chan}), 32'b1000);

    repeat (3) @(negedge clk);
    chk(rq.size() == 0, "R2 responses outstanding", 32'(rq.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule